// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 16-bit program counter of a single-cycle, word-addressed processor and chooses its next value from the instruction being executed. Each cycle it looks at the top four bits of the instruction word. From these it decides whether to step to the next word, jump to an absolute target, jump and save a return address, branch relative to the current PC when a flag condition holds, or return through the link register.

The current PC drives the instruction fetch address. During a jump-and-link the block also raises a write request for the link register, r15, and supplies the value to write. The register file, the ALU, the flag logic and data memory are outside this block. The block receives the four status flags and the current link register contents as inputs.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0x0000 at the next rising edge, and the link write enable is low while reset is high.
- R2: Opcodes (instr[15:12]) 0000, 0001, 0100, 0101, 0110, 0111 and a conditional branch that is not taken advance the PC by 1, wrapping from 0xFFFF to 0x0000.
- R3: Opcode 10xx (jump) loads instr[13:0] into PC[13:0] and keeps PC[15:14].
- R4: Opcode 11xx (jump-and-link) loads PC[13:0] the same way as R3 and keeps PC[15:14].
- R5: During a jump-and-link cycle, the link write enable is high and the link write data equals the PC of that same instruction. In every other cycle the enable is low.
- R6: Opcode 0011 (return) loads the PC from the link register input.
- R7: Opcode 0010 (branch) evaluates a condition mask in instr[11:8], whose bits 11, 10, 9 and 8 correspond to the flags V, C, N and Z. The flag input is ordered {V,C,N,Z}. The branch is taken only when every mask bit set to 1 has its flag at 1, so a zero mask always branches.
- R8: A taken branch adds instr[7:0], sign-extended to 16 bits, to the PC of the branch, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word at the current PC |
| flags | input | 4 | Status flags {V,C,N,Z} |
| link_val | input | 16 | Current contents of r15 |
| pc | output | 16 | Program counter / fetch address |
| link_we | output | 1 | Write request for r15 |
| link_wd | output | 16 | Value to write to r15 |

## Verification
The next PC value is registered, so a change in the instruction or flags appears on `pc` after exactly one rising edge. The bench computes the expected next PC from the PC it sampled before that edge and the stimulus it drove, then samples `pc` on the following falling edge. The link write outputs are combinational. The bench checks them in the same half-cycle in which the instruction is presented, before the clock edge that consumes that instruction.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int W = 16,
  parameter int JW = 14,
  parameter int OW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] instr,
  input  logic [3:0]   flags,
  input  logic [W-1:0] link_val,
  output logic [W-1:0] pc,
  output logic         link_we,
  output logic [W-1:0] link_wd
);
  logic [3:0]   op;
  logic [3:0]   mask;
  logic         cond_ok;
  logic [W-1:0] offs;
  logic [W-1:0] pc_next;

  assign op      = instr[W-1:W-4];
  assign mask    = instr[11:8];
  assign cond_ok = ((mask & ~flags) == 4'b0000);
  assign offs    = {{(W-OW){instr[OW-1]}}, instr[OW-1:0]};

  assign link_we = !rst && (op[3:2] == 2'b11);
  assign link_wd = pc;

  always_comb begin
    pc_next = pc + 1'b1;
    if (op[3])
      pc_next = {pc[W-1:JW], instr[JW-1:0]};
    else if (op == 4'b0011)
      pc_next = link_val;
    else if (op == 4'b0010 && cond_ok)
      pc_next = pc + offs;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic [15:0] link_val,
  input logic [15:0] pc,
  input logic        link_we,
  input logic [15:0] link_wd
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == 16'h0000);
  a_r1_no_link_in_reset: assert property (@(posedge clk) rst |-> !link_we);
  a_r3_keep_top: assert property (@(posedge clk) disable iff (rst)
    instr[15] |=> pc[15:14] == $past(pc[15:14]) && pc[13:0] == $past(instr[13:0]));
  a_r5_link_data: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_wd == pc && instr[15:14] == 2'b11);
  a_r5_link_only_jl: assert property (@(posedge clk) disable iff (rst)
    instr[15:14] != 2'b11 |-> !link_we);
  a_r6_return: assert property (@(posedge clk) disable iff (rst)
    instr[15:12] == 4'b0011 |=> pc == $past(link_val));
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (instr[15:12] inside {4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b0110, 4'b0111})
    |=> pc == $past(pc) + 16'd1);
endmodule

bind pc_sequencer pc_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .link_val(link_val),
  .pc(pc), .link_we(link_we), .link_wd(link_wd)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] instr = 0;
  logic [3:0]  flags = 0;
  logic [15:0] link_val = 0;
  logic [15:0] pc;
  logic        link_we;
  logic [15:0] link_wd;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_sequencer i_pc_sequencer (.*);

  function automatic logic [15:0] exp_next(logic [15:0] p, logic [15:0] ins,
                                           logic [3:0] f, logic [15:0] lk);
    logic [3:0] o;
    o = ins[15:12];
    if (o[3]) return {p[15:14], ins[13:0]};
    if (o == 4'b0011) return lk;
    if (o == 4'b0010) begin
      if ((ins[11] && !f[3]) || (ins[10] && !f[2]) ||
          (ins[9] && !f[1]) || (ins[8] && !f[0])) return p + 16'd1;
      return p + {{8{ins[7]}}, ins[7:0]};
    end
    return p + 16'd1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic [15:0] ins, logic [3:0] f, logic [15:0] lk);
    logic [15:0] p0;
    instr = ins; flags = f; link_val = lk;
    #1;
    p0 = pc;
    check("R5", {link_we, link_wd}, {(ins[15:14] == 2'b11), p0});
    @(negedge clk);
    check(req, pc, exp_next(p0, ins, f, lk));
  endtask

  task automatic go_to(logic [15:0] t);
    step("R6", 16'h3000, 4'h0, t);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", pc, 16'h0000);
    check("R1", link_we, 0);
    rst = 0; instr = 16'h0000;
    step("R2", 16'h0123, 0, 0);
    step("R2", 16'h1a5c, 0, 0);
    go_to(16'hFFFF);
    step("R2", 16'h5013, 0, 0);
    check("R2", pc, 16'h0000);
    go_to(16'hC010);
    step("R3", 16'h8123, 0, 0);
    check("R3", pc, 16'hC123);
    go_to(16'h4005);
    step("R4", 16'hF3FF, 0, 0);
    check("R4", pc, 16'h73FF);
    go_to(16'h0030);
    step("R8", 16'h20F4, 4'h0, 0);
    check("R8", pc, 16'h0024);
    step("R7", 16'h2105, 4'hE, 0);
    check("R7", pc, 16'h0025);
    step("R7", 16'h2F05, 4'hF, 0);
    check("R7", pc, 16'h002A);
    step("R7", 16'h2805, 4'h7, 0);
    go_to(16'h0002);
    step("R8", 16'h2080, 0, 0);
    check("R8", pc, 16'hFF82);
    go_to(16'hFFF0);
    step("R8", 16'h2020, 0, 0);
    check("R8", pc, 16'h0010);
    instr = 16'hC000; rst = 1; #1;
    check("R1", link_we, 0);
    @(negedge clk);
    check("R1", pc, 16'h0000);
    rst = 0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      step(r[15:12] == 4'b0010 ? "R7" : r[15:12] == 4'b0011 ? "R6" :
           r[15] ? "R3" : "R2", r, 4'($urandom), 16'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); fails++; runs++;
            $display("FAIL watchdog"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule